// File: doc/BRIEF.md
# Full-Bridge Gate Control Sequencer

This block is the digital control for an H-bridge built from two independent half-bridges, A and B. Each half receives a high-side command and a low-side command. Both halves share a disable input and an undervoltage flag. The block turns these into four registered gate-enable outputs. Within a half it settles conflicting commands in favour of the low-side switch. It adds a programmable turn-on delay, one for the high-side switches and a separate one for the low-side switches. Turn-off has no added delay.

All inputs are asynchronous and pass through two-flop synchronizers. While disable or undervoltage is active, all four gates stay off. When both are released, and also after reset, the block runs a recovery sequence. First both low-side gates are driven on for a refresh window, so the external bootstrap capacitors can recharge. The high-side gates are held off until a later, longer window has expired. After that the halves follow their commands.

If a half's high-side command is tied high, its low-side command alone drives the half as a complementary pair, with the delays inserted at every edge. All timing values are parameters counted in system clock cycles. The defaults assume a 100 MHz clock: a 410 ns refresh, high-side enable 620 ns after release, 60 ns high-side delay and 40 ns low-side delay.

Top module: `hbg_gate_seq`

## Requirements
- R1: While reset is asserted, all four gates are off. After reset is released, the block runs the same refresh and high-side enable sequence as after a lock release (R10, R12), with the same cycle timing.
- R2: A high level on the disable input turns all four gates off, whatever the command inputs are. The gates go off at the third rising clock edge after the disable level is first sampled, counting the sampling edge as the first. They stay off for as long as disable is held.
- R3: An active undervoltage flag turns all four gates off with the same timing as R2, whatever the command inputs are.
- R4: Within a half, a high low-side command turns the high-side gate off and the low-side gate on, even when the high-side command is also high. The high-side and low-side gates of one half are never on in the same cycle.
- R5: Within a half, the high-side gate can be on only while the low-side command is low and the high-side command is high. When both commands are low, both gates of the half go off.
- R6: A high-side gate turns on HI_DEAD_CYC+2 edges after the edge that first samples its enabling command. It turns off 2 edges after the edge that first samples the command's removal.
- R7: A low-side gate turns on LO_DEAD_CYC+2 edges after the edge that first samples its low-side command high. It turns off 2 edges after the edge that first samples the command low.
- R8: A command that is removed before its turn-on delay has run out causes no gate pulse. The next rising command waits out the full delay again.
- R9: With the high-side command held high, toggling the low-side command switches the half between its two gates, applying the turn-on delay of the gate being enabled at each transition.
- R10: After disable and undervoltage are both released, both low-side gates are on for exactly REFRESH_CYC cycles. The pulse begins at the fourth edge after the edge that first samples the release, counting the sampling edge as the first.
- R11: Commands to one half have no effect on the gates of the other half.
- R12: After a release, no high-side gate turns on before HI_EN_CYC cycles of the release sequence have passed. A held high-side command then turns on after its normal delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmdHiA | input | 1 | High-side command, half A (asynchronous) |
| cmdLoA | input | 1 | Low-side command, half A (asynchronous) |
| cmdHiB | input | 1 | High-side command, half B (asynchronous) |
| cmdLoB | input | 1 | Low-side command, half B (asynchronous) |
| disableIn | input | 1 | Shared disable, active high (asynchronous) |
| uvFlag | input | 1 | Shared undervoltage flag, active high (asynchronous) |
| gateHiA | output | 1 | High-side gate enable, half A |
| gateLoA | output | 1 | Low-side gate enable, half A |
| gateHiB | output | 1 | High-side gate enable, half B |
| gateLoB | output | 1 | Low-side gate enable, half B |

## Verification
The bench targets the exact edge on which each gate changes. A design that delays turn-off, or that counts its dead time one cycle short or long, moves that edge and fails the check. Both commands are driven high at once in one half while the other half runs. This exposes a design that lets the high side win, that lets both gates overlap for a cycle, or that leaks one half's commands into the other. The recovery sequence is followed cycle by cycle after reset, after disable and after undervoltage. A wrong refresh length, a high-side gate enabled too early, or a missing refresh after reset each shows up as a wrong gate on a specific cycle. Short command pulses check that an unexpired turn-on delay is cancelled and not left running, which a design would reveal as a stray or early gate pulse.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  // strobes from the lock/recovery control to each half-bridge datapath
  typedef struct packed {
    logic forceOff;   // lock active: every gate off
    logic forceLoOn;  // recovery refresh: low-side gates on
    logic hiAllow;    // recovery complete: high-side gates may turn on
  } hbg_strobe_t;

  typedef enum logic [1:0] {
    ST_LOCK    = 2'd0,
    ST_REFRESH = 2'd1,
    ST_RUN     = 2'd2
  } hbg_state_t;

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int   WIDTH     = 1,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1  <= {WIDTH{RESET_VAL}};
      syncOut <= {WIDTH{RESET_VAL}};
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end

endmodule

// File: rtl/hbg_ctrl.sv
module hbg_ctrl
  import hbg_pkg::*;
#(
  parameter int REFRESH_CYC = 41,
  parameter int HI_EN_CYC   = 62
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        disableIn,
  input  logic        uvFlag,
  output hbg_strobe_t strobe
);

  localparam int REL_W = $clog2(HI_EN_CYC + 1);
  localparam logic [REL_W-1:0] REL_LAST = REL_W'(HI_EN_CYC - 1);
  localparam logic [REL_W-1:0] REF_LIM  = REL_W'(REFRESH_CYC);

  logic [1:0]       lockSync;
  logic             lock;
  hbg_state_t       state;
  logic [REL_W-1:0] relCnt;

  // lock inputs reset to the locked level so reset looks like a release
  hbg_sync #(.WIDTH(2), .RESET_VAL(1'b1)) u_lockSync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn ({uvFlag, disableIn}),
    .syncOut (lockSync)
  );

  assign lock = |lockSync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_LOCK;
      relCnt <= '0;
    end else if (lock) begin
      state  <= ST_LOCK;
      relCnt <= '0;
    end else begin
      unique case (state)
        ST_LOCK: begin
          state  <= ST_REFRESH;
          relCnt <= '0;
        end
        ST_REFRESH: begin
          if (relCnt == REL_LAST) state <= ST_RUN;
          else relCnt <= relCnt + 1'b1;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    strobe.forceOff  = lock || (state == ST_LOCK);
    strobe.forceLoOn = (state == ST_REFRESH) && (relCnt < REF_LIM);
    strobe.hiAllow   = (state == ST_RUN);
  end

endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
  import hbg_pkg::*;
#(
  parameter int HI_DEAD_CYC = 6,
  parameter int LO_DEAD_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdHi,
  input  logic        cmdLo,
  input  hbg_strobe_t strobe,
  output logic        gateHi,
  output logic        gateLo
);

  localparam int HI_W = $clog2(HI_DEAD_CYC + 1) > 0 ? $clog2(HI_DEAD_CYC + 1) : 1;
  localparam int LO_W = $clog2(LO_DEAD_CYC + 1) > 0 ? $clog2(LO_DEAD_CYC + 1) : 1;
  localparam logic [HI_W-1:0] HI_LIM = HI_W'(HI_DEAD_CYC);
  localparam logic [LO_W-1:0] LO_LIM = LO_W'(LO_DEAD_CYC);

  logic [1:0]      cmdSync;
  logic            hiReq;
  logic            loReq;
  logic [HI_W-1:0] hiCnt;
  logic [LO_W-1:0] loCnt;

  hbg_sync #(.WIDTH(2), .RESET_VAL(1'b0)) u_cmdSync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn ({cmdHi, cmdLo}),
    .syncOut (cmdSync)
  );

  // low-side command wins; high side also waits for recovery to finish
  always_comb begin
    hiReq = !strobe.forceOff && strobe.hiAllow && !strobe.forceLoOn &&
            cmdSync[1] && !cmdSync[0];
    loReq = !strobe.forceOff && (strobe.forceLoOn || cmdSync[0]);
  end

  // delayed turn-on, immediate turn-off; a dropped request clears the count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiCnt  <= '0;
      gateHi <= 1'b0;
    end else if (!hiReq) begin
      hiCnt  <= '0;
      gateHi <= 1'b0;
    end else if (hiCnt == HI_LIM) begin
      gateHi <= 1'b1;
    end else begin
      hiCnt <= hiCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loCnt  <= '0;
      gateLo <= 1'b0;
    end else if (!loReq) begin
      loCnt  <= '0;
      gateLo <= 1'b0;
    end else begin
      if (loCnt != LO_LIM) loCnt <= loCnt + 1'b1;
      gateLo <= gateLo || strobe.forceLoOn || (loCnt == LO_LIM);
    end
  end

endmodule

// File: rtl/hbg_gate_seq.sv
module hbg_gate_seq
  import hbg_pkg::*;
#(
  parameter int HI_DEAD_CYC = 6,
  parameter int LO_DEAD_CYC = 4,
  parameter int REFRESH_CYC = 41,
  parameter int HI_EN_CYC   = 62
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmdHiA,
  input  logic cmdLoA,
  input  logic cmdHiB,
  input  logic cmdLoB,
  input  logic disableIn,
  input  logic uvFlag,
  output logic gateHiA,
  output logic gateLoA,
  output logic gateHiB,
  output logic gateLoB
);

  localparam int NUM_HALVES = 2;

  hbg_strobe_t ctrlStrobe;
  logic [NUM_HALVES-1:0] cmdHiVec;
  logic [NUM_HALVES-1:0] cmdLoVec;
  logic [NUM_HALVES-1:0] gateHiVec;
  logic [NUM_HALVES-1:0] gateLoVec;

  assign cmdHiVec = {cmdHiB, cmdHiA};
  assign cmdLoVec = {cmdLoB, cmdLoA};

  hbg_ctrl #(
    .REFRESH_CYC (REFRESH_CYC),
    .HI_EN_CYC   (HI_EN_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .disableIn (disableIn),
    .uvFlag    (uvFlag),
    .strobe    (ctrlStrobe)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    hbg_leg #(
      .HI_DEAD_CYC (HI_DEAD_CYC),
      .LO_DEAD_CYC (LO_DEAD_CYC)
    ) u_leg (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmdHi  (cmdHiVec[h]),
      .cmdLo  (cmdLoVec[h]),
      .strobe (ctrlStrobe),
      .gateHi (gateHiVec[h]),
      .gateLo (gateLoVec[h])
    );
  end

  assign gateHiA = gateHiVec[0];
  assign gateLoA = gateLoVec[0];
  assign gateHiB = gateHiVec[1];
  assign gateLoB = gateLoVec[1];

endmodule

// File: rtl/hbg_checker.sv
module hbg_checker
  import hbg_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        uvFlag,
  input hbg_strobe_t strobe,
  input logic        gateHiA,
  input logic        gateLoA,
  input logic        gateHiB,
  input logic        gateLoB
);

  assert_excl_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(gateHiA && gateLoA));

  assert_excl_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(gateHiB && gateLoB));

  assert_lock_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.forceOff |=> !(gateHiA || gateLoA || gateHiB || gateLoB));

  assert_uv_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (uvFlag && $past(uvFlag) && $past(uvFlag, 2) && $past(uvFlag, 3))
      |-> !(gateHiA || gateLoA || gateHiB || gateLoB));

  assert_refresh_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.forceLoOn |=> (gateLoA && gateLoB));

  assert_hi_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gateHiA) || $rose(gateHiB)) |-> $past(strobe.hiAllow));

  assert_hi_after_lo_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gateHiA) |-> !$past(gateLoA));

endmodule

bind hbg_gate_seq hbg_checker u_hbgChecker (
  .clk     (clk),
  .rst_n   (rst_n),
  .uvFlag  (uvFlag),
  .strobe  (ctrlStrobe),
  .gateHiA (gateHiA),
  .gateLoA (gateLoA),
  .gateHiB (gateHiB),
  .gateLoB (gateLoB)
);

// File: tb/test_hbg_gate_seq.sv
module test_hbg_gate_seq;

  localparam int CLK_PERIOD = 10;
  localparam int HI_DEAD    = 6;
  localparam int LO_DEAD    = 4;
  localparam int REF_CYC    = 41;
  localparam int HEN_CYC    = 62;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdHiA = 1'b0, cmdLoA = 1'b0, cmdHiB = 1'b0, cmdLoB = 1'b0;
  logic disableIn = 1'b0, uvFlag = 1'b0;
  logic gateHiA, gateLoA, gateHiB, gateLoB;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hbg_gate_seq #(
    .HI_DEAD_CYC (HI_DEAD),
    .LO_DEAD_CYC (LO_DEAD),
    .REFRESH_CYC (REF_CYC),
    .HI_EN_CYC   (HEN_CYC)
  ) i_hbg_gate_seq (
    .clk (clk), .rst_n (rst_n),
    .cmdHiA (cmdHiA), .cmdLoA (cmdLoA), .cmdHiB (cmdHiB), .cmdLoB (cmdLoB),
    .disableIn (disableIn), .uvFlag (uvFlag),
    .gateHiA (gateHiA), .gateLoA (gateLoA), .gateHiB (gateHiB), .gateLoB (gateLoB)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic chkAll(input string tag, input logic eHA, input logic eLA,
                        input logic eHB, input logic eLB);
    chk({tag, " gateHiA"}, gateHiA, eHA);
    chk({tag, " gateLoA"}, gateLoA, eLA);
    chk({tag, " gateHiB"}, gateHiB, eHB);
    chk({tag, " gateLoB"}, gateLoB, eLB);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // R4: same-half overlap watched on every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if ((gateHiA && gateLoA) || (gateHiB && gateLoB)) begin
        failures++;
        $display("FAIL R4 overlap actual=%0b%0b%0b%0b expected=no pair", gateHiA, gateLoA, gateHiB, gateLoB);
      end
    end
  end

  // called at the negedge where the lock or reset was just released,
  // with both high-side commands held high and low-side commands low
  task automatic checkRelease(input string tag);
    for (int i = 1; i <= HEN_CYC + HI_DEAD + 5; i++) begin
      step();
      chkAll(tag, i >= HEN_CYC + HI_DEAD + 4, (i >= 4) && (i <= REF_CYC + 3),
             i >= HEN_CYC + HI_DEAD + 4, (i >= 4) && (i <= REF_CYC + 3));
    end
  endtask

  task automatic testReset();
    cmdHiA = 1'b1; cmdHiB = 1'b1;
    repeat (4) step();
    chkAll("R1 during reset", 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    checkRelease("R1 R10 R12 after reset");
  endtask

  task automatic testPriority();
    // both highs on; raise A low command as well (R4), B untouched (R11)
    cmdLoA = 1'b1;
    for (int i = 1; i <= LO_DEAD + 4; i++) begin
      step();
      chkAll("R4 R11 priority", i < 3, i >= LO_DEAD + 3, 1'b1, 1'b0);
    end
    // R9: high held, low drops -> low off, high on after its delay
    cmdLoA = 1'b0;
    for (int i = 1; i <= HI_DEAD + 4; i++) begin
      step();
      chkAll("R9 complementary", i >= HI_DEAD + 3, i < 3, 1'b1, 1'b0);
    end
    cmdLoA = 1'b1;
    for (int i = 1; i <= LO_DEAD + 4; i++) begin
      step();
      chkAll("R9 complementary back", i < 3, i >= LO_DEAD + 3, 1'b1, 1'b0);
    end
  endtask

  task automatic testBothLow();
    cmdHiA = 1'b0; cmdLoA = 1'b0;
    for (int i = 1; i <= 5; i++) begin
      step();
      chkAll("R5 both low", 1'b0, i < 3, 1'b1, 1'b0);
    end
  endtask

  task automatic testHiDelay();
    cmdHiA = 1'b1;
    for (int i = 1; i <= HI_DEAD + 4; i++) begin
      step();
      chk("R6 hi turn-on", gateHiA, i >= HI_DEAD + 3);
    end
    cmdHiA = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      step();
      chk("R6 hi turn-off", gateHiA, i < 3);
    end
  endtask

  task automatic testLoDelay();
    cmdLoB = 1'b1;
    for (int i = 1; i <= LO_DEAD + 4; i++) begin
      step();
      chkAll("R7 lo turn-on B", 1'b0, 1'b0, i < 3, i >= LO_DEAD + 3);
    end
    cmdLoB = 1'b0;
    for (int i = 1; i <= HI_DEAD + 4; i++) begin
      step();
      chk("R7 lo turn-off B", gateLoB, i < 3);
    end
  endtask

  task automatic testCancel();
    cmdHiA = 1'b1;
    repeat (HI_DEAD - 1) @(negedge clk);
    cmdHiA = 1'b0;
    for (int i = 1; i <= HI_DEAD + 6; i++) begin
      step();
      chk("R8 short pulse no gate", gateHiA, 1'b0);
    end
    cmdHiA = 1'b1;
    for (int i = 1; i <= HI_DEAD + 4; i++) begin
      step();
      chk("R8 full delay restarts", gateHiA, i >= HI_DEAD + 3);
    end
  endtask

  task automatic testLock(input bit useUv);
    cmdHiA = 1'b1; cmdLoA = 1'b0; cmdHiB = 1'b1; cmdLoB = 1'b0;
    repeat (HI_DEAD + 4) step();
    chkAll(useUv ? "R3 pre" : "R2 pre", 1'b1, 1'b0, 1'b1, 1'b0);
    if (useUv) uvFlag = 1'b1; else disableIn = 1'b1;
    for (int i = 1; i <= 3; i++) begin
      step();
      chkAll(useUv ? "R3 turn-off" : "R2 turn-off", i < 3, 1'b0, i < 3, 1'b0);
    end
    cmdLoA = 1'b1; cmdHiB = 1'b0; cmdLoB = 1'b1;
    repeat (LO_DEAD + 6) step();
    chkAll(useUv ? "R3 held low cmds" : "R2 held low cmds", 1'b0, 1'b0, 1'b0, 1'b0);
    cmdLoA = 1'b0; cmdHiB = 1'b1; cmdLoB = 1'b0;
    repeat (HI_DEAD + 6) step();
    chkAll(useUv ? "R3 held high cmds" : "R2 held high cmds", 1'b0, 1'b0, 1'b0, 1'b0);
    if (useUv) uvFlag = 1'b0; else disableIn = 1'b0;
    checkRelease(useUv ? "R10 R12 after uv" : "R10 R12 after disable");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testPriority();
    testBothLow();
    testHiDelay();
    testLoDelay();
    testCancel();
    testLock(1'b0);
    testLock(1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule